// File: doc/BRIEF.md
# Dual-Port Hardware Token Lock (eight tokens)

This block holds a small set of shared tokens that two agents, called the left and the right port, use to coordinate ownership of a common resource. Each port issues single-cycle accesses: a write of data 0 asks for a token, a write of data 1 gives it back, and a read tells the port whether it currently owns the token. A request that cannot be served at once is kept as pending. The token is handed to the waiting port on the clock edge where the holder lets go, so software on the waiting side only has to poll its own read-back.

All state is synchronous to one clock and is cleared by an active-low asynchronous reset. Read data is combinational from the addressed token and reflects the state after the last clock edge. When the two ports claim the same free token on the same edge, the left port wins and the right request stays pending.

Top module: `tok_sem8`

## Requirements
- R1: There are NUM_TOK (default 8) independent tokens, addressed by the IDX_W-bit (default 3) index. An access to one index never changes the state of any other token.
- R2: A port access takes effect only when both its select and its enable are 1. With either at 0, a write changes nothing and the read data is 1.
- R3: A write with data 0 to a token that is free and has no waiting request makes the writing port its holder at that clock edge.
- R4: A read (select=1, enable=1, write=0) returns 0 when the reading port holds the addressed token and 1 otherwise.
- R5: At no time do both ports hold the same token.
- R6: A request for a token held by the other port is kept pending. When the holder writes 1 to that token, ownership passes to the waiting port at the same clock edge.
- R7: When both ports write 0 to the same free token on the same edge, the left port becomes holder and the right request stays pending.
- R8: A write of 1 from a port that neither holds nor waits for the token has no effect. A write of 1 from a port that is waiting cancels its pending request.
- R9: After reset every token is free with no pending request, and both ports read 1 on every index.
- R10: A write of 0 from the port that already holds the token leaves the state unchanged, so one write of 1 then frees it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel | input | 1 | Left port token-space select |
| l_en | input | 1 | Left port enable |
| l_wr | input | 1 | Left port write (1) or read (0) |
| l_idx | input | IDX_W | Left port token index |
| l_wdata | input | 1 | Left port write bit: 0 requests, 1 releases |
| l_rdata | output | 1 | Left port read bit: 0 means held by left |
| r_sel | input | 1 | Right port token-space select |
| r_en | input | 1 | Right port enable |
| r_wr | input | 1 | Right port write (1) or read (0) |
| r_idx | input | IDX_W | Right port token index |
| r_wdata | input | 1 | Right port write bit: 0 requests, 1 releases |
| r_rdata | output | 1 | Right port read bit: 0 means held by right |

## Verification
The assertions take for granted that all port inputs are synchronous to the clock, free of X while select and enable are both 1, and stable around the rising edge. They also rely on one access per port per cycle, which the port format enforces. The bench keeps within these limits by changing every input on the falling edge only, returning select and enable to 0 between accesses, and sampling read data shortly after the falling edge where the combinational path has settled.

// File: rtl/tok_sem_pkg.sv
package tok_sem_pkg;

  // State of one token: who holds it and who is waiting for it
  typedef struct packed {
    logic hold_l;
    logic hold_r;
    logic pend_l;
    logic pend_r;
  } tok_state_t;

  localparam tok_state_t TOK_IDLE = '{hold_l: 1'b0, hold_r: 1'b0, pend_l: 1'b0, pend_r: 1'b0};

  // An access counts only with both select and enable high
  function automatic logic port_live(input logic sel, input logic en);
    return sel & en;
  endfunction

  // One clock step of a token. Releases and cancels are applied first,
  // then new requests, then a free token goes to the waiting side with
  // the left side ahead of the right.
  function automatic tok_state_t tok_step(input tok_state_t s,
                                          input logic req_l, input logic rel_l,
                                          input logic req_r, input logic rel_r);
    tok_state_t n;
    n = s;
    if (rel_l) begin
      n.hold_l = 1'b0;
      n.pend_l = 1'b0;
    end
    if (rel_r) begin
      n.hold_r = 1'b0;
      n.pend_r = 1'b0;
    end
    if (req_l && !n.hold_l) n.pend_l = 1'b1;
    if (req_r && !n.hold_r) n.pend_r = 1'b1;
    if (!n.hold_l && !n.hold_r) begin
      if (n.pend_l) begin
        n.hold_l = 1'b1;
        n.pend_l = 1'b0;
      end else if (n.pend_r) begin
        n.hold_r = 1'b1;
        n.pend_r = 1'b0;
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/tok_port_dec.sv
module tok_port_dec
  import tok_sem_pkg::*;
#(
  parameter int unsigned NUM_TOK = 8,
  parameter int unsigned IDX_W   = $clog2(NUM_TOK)
) (
  input  logic               sel,
  input  logic               en,
  input  logic               wr,
  input  logic [IDX_W-1:0]   idx,
  input  logic               wdata,
  output logic [NUM_TOK-1:0] req_v,
  output logic [NUM_TOK-1:0] rel_v,
  output logic               rd_live
);

  localparam logic [NUM_TOK-1:0] ONE = {{(NUM_TOK-1){1'b0}}, 1'b1};

  logic               live;
  logic [NUM_TOK-1:0] pick;

  assign live    = port_live(sel, en);
  assign pick    = ONE << idx;
  assign req_v   = (live && wr && !wdata) ? pick : '0;
  assign rel_v   = (live && wr &&  wdata) ? pick : '0;
  assign rd_live = live && !wr;

endmodule

// File: rtl/tok_cell.sv
module tok_cell
  import tok_sem_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_l,
  input  logic       rel_l,
  input  logic       req_r,
  input  logic       rel_r,
  output tok_state_t st
);

  tok_state_t st_nx;

  always_comb st_nx = tok_step(st, req_l, rel_l, req_r, rel_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= TOK_IDLE;
    else        st <= st_nx;
  end

endmodule

// File: rtl/tok_rd_mux.sv
module tok_rd_mux #(
  parameter int unsigned NUM_TOK = 8,
  parameter int unsigned IDX_W   = $clog2(NUM_TOK)
) (
  input  logic               rd_live,
  input  logic [IDX_W-1:0]   idx,
  input  logic [NUM_TOK-1:0] hold_v,
  output logic               rdata
);

  // Low-true ownership view; idle port reads 1
  assign rdata = rd_live ? ~hold_v[idx] : 1'b1;

endmodule

// File: rtl/tok_sem8.sv
module tok_sem8
  import tok_sem_pkg::*;
#(
  parameter int unsigned NUM_TOK = 8,
  parameter int unsigned IDX_W   = $clog2(NUM_TOK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             l_sel,
  input  logic             l_en,
  input  logic             l_wr,
  input  logic [IDX_W-1:0] l_idx,
  input  logic             l_wdata,
  output logic             l_rdata,
  input  logic             r_sel,
  input  logic             r_en,
  input  logic             r_wr,
  input  logic [IDX_W-1:0] r_idx,
  input  logic             r_wdata,
  output logic             r_rdata
);

  logic [NUM_TOK-1:0] req_l_v, rel_l_v, req_r_v, rel_r_v;
  logic               l_rd_live, r_rd_live;
  // Named state vectors, brought out for the checker
  logic [NUM_TOK-1:0] hold_l_v, hold_r_v, pend_l_v, pend_r_v;

  tok_port_dec #(.NUM_TOK(NUM_TOK), .IDX_W(IDX_W)) u_dec_l (
    .sel(l_sel), .en(l_en), .wr(l_wr), .idx(l_idx), .wdata(l_wdata),
    .req_v(req_l_v), .rel_v(rel_l_v), .rd_live(l_rd_live)
  );

  tok_port_dec #(.NUM_TOK(NUM_TOK), .IDX_W(IDX_W)) u_dec_r (
    .sel(r_sel), .en(r_en), .wr(r_wr), .idx(r_idx), .wdata(r_wdata),
    .req_v(req_r_v), .rel_v(rel_r_v), .rd_live(r_rd_live)
  );

  for (genvar k = 0; k < NUM_TOK; k++) begin : g_tok
    tok_state_t st;
    tok_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .req_l(req_l_v[k]), .rel_l(rel_l_v[k]),
      .req_r(req_r_v[k]), .rel_r(rel_r_v[k]),
      .st(st)
    );
    assign hold_l_v[k] = st.hold_l;
    assign hold_r_v[k] = st.hold_r;
    assign pend_l_v[k] = st.pend_l;
    assign pend_r_v[k] = st.pend_r;
  end

  tok_rd_mux #(.NUM_TOK(NUM_TOK), .IDX_W(IDX_W)) u_rd_l (
    .rd_live(l_rd_live), .idx(l_idx), .hold_v(hold_l_v), .rdata(l_rdata)
  );

  tok_rd_mux #(.NUM_TOK(NUM_TOK), .IDX_W(IDX_W)) u_rd_r (
    .rd_live(r_rd_live), .idx(r_idx), .hold_v(hold_r_v), .rdata(r_rdata)
  );

endmodule

// File: rtl/tok_sem_chk.sv
module tok_sem_chk #(
  parameter int unsigned NUM_TOK = 8,
  parameter int unsigned IDX_W   = $clog2(NUM_TOK)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               l_sel,
  input logic               l_en,
  input logic               l_wr,
  input logic [IDX_W-1:0]   l_idx,
  input logic               l_wdata,
  input logic               l_rdata,
  input logic               r_sel,
  input logic               r_en,
  input logic               r_wr,
  input logic [IDX_W-1:0]   r_idx,
  input logic               r_wdata,
  input logic               r_rdata,
  input logic [NUM_TOK-1:0] hold_l_v,
  input logic [NUM_TOK-1:0] hold_r_v,
  input logic [NUM_TOK-1:0] pend_l_v,
  input logic [NUM_TOK-1:0] pend_r_v
);

  logic l_act, r_act;
  assign l_act = l_sel && l_en;
  assign r_act = r_sel && r_en;

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_l_v & hold_r_v) == '0);

  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_act && !r_act) |=> $stable({hold_l_v, hold_r_v, pend_l_v, pend_r_v}));

  assert_idle_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_act |-> l_rdata) and (!r_act |-> r_rdata));

  assert_read_view_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (l_act && !l_wr && !l_rdata) |-> hold_l_v[l_idx]);

  assert_read_view_r_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (r_act && !r_wr && !r_rdata) |-> hold_r_v[r_idx]);

  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |=> ({hold_l_v, hold_r_v, pend_l_v, pend_r_v} == '0));

  for (genvar k = 0; k < NUM_TOK; k++) begin : g_chk
    localparam logic [IDX_W-1:0] KI = IDX_W'(k);
    logic l_hit, r_hit;
    assign l_hit = l_act && (l_idx == KI);
    assign r_hit = r_act && (r_idx == KI);

    assert_handoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (l_hit && l_wr && l_wdata && hold_l_v[k] && pend_r_v[k] && !r_hit) |=> hold_r_v[k]);

    assert_tie_left_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (l_hit && l_wr && !l_wdata && r_hit && r_wr && !r_wdata &&
       !hold_l_v[k] && !hold_r_v[k] && !pend_l_v[k] && !pend_r_v[k])
      |=> (hold_l_v[k] && pend_r_v[k]));

    assert_stray_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (r_hit && r_wr && r_wdata && !hold_r_v[k] && !pend_r_v[k] && !l_hit)
      |=> $stable({hold_l_v[k], hold_r_v[k], pend_l_v[k], pend_r_v[k]}));

    assert_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (r_hit && r_wr && r_wdata && pend_r_v[k]) |=> (!pend_r_v[k] && !hold_r_v[k]));
  end

endmodule

bind tok_sem8 tok_sem_chk #(.NUM_TOK(NUM_TOK), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_sel(l_sel), .l_en(l_en), .l_wr(l_wr), .l_idx(l_idx), .l_wdata(l_wdata), .l_rdata(l_rdata),
  .r_sel(r_sel), .r_en(r_en), .r_wr(r_wr), .r_idx(r_idx), .r_wdata(r_wdata), .r_rdata(r_rdata),
  .hold_l_v(hold_l_v), .hold_r_v(hold_r_v), .pend_l_v(pend_l_v), .pend_r_v(pend_r_v)
);

// File: tb/sim_tok_sem8.sv
module sim_tok_sem8;

  localparam int CLK_PERIOD = 10;
  localparam int NT = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_sel = 0, l_en = 0, l_wr = 0, l_wdata = 0;
  logic r_sel = 0, r_en = 0, r_wr = 0, r_wdata = 0;
  logic [IW-1:0] l_idx = '0, r_idx = '0;
  logic l_rdata, r_rdata;
  int total = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tok_sem8 #(.NUM_TOK(NT), .IDX_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_en(l_en), .l_wr(l_wr), .l_idx(l_idx), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_en(r_en), .r_wr(r_wr), .r_idx(r_idx), .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic idle_all();
    l_sel = 0; l_en = 0; l_wr = 0; l_wdata = 0;
    r_sel = 0; r_en = 0; r_wr = 0; r_wdata = 0;
  endtask

  // One write; side 0 = left, 1 = right. Commits at the next rising edge.
  task automatic wr1(input bit side, input int idx, input logic val,
                     input logic sel = 1, input logic en = 1);
    @(negedge clk);
    if (!side) begin l_sel = sel; l_en = en; l_wr = 1; l_idx = IW'(idx); l_wdata = val; end
    else       begin r_sel = sel; r_en = en; r_wr = 1; r_idx = IW'(idx); r_wdata = val; end
    @(negedge clk);
    idle_all();
  endtask

  task automatic wr_both(input int idx, input logic lv, input logic rv);
    @(negedge clk);
    l_sel = 1; l_en = 1; l_wr = 1; l_idx = IW'(idx); l_wdata = lv;
    r_sel = 1; r_en = 1; r_wr = 1; r_idx = IW'(idx); r_wdata = rv;
    @(negedge clk);
    idle_all();
  endtask

  // Combinational read, sampled inside the low phase
  task automatic rd1(input bit side, input int idx, output logic v,
                     input logic sel = 1, input logic en = 1);
    @(negedge clk);
    if (!side) begin l_sel = sel; l_en = en; l_wr = 0; l_idx = IW'(idx); end
    else       begin r_sel = sel; r_en = en; r_wr = 0; r_idx = IW'(idx); end
    #1;
    v = side ? r_rdata : l_rdata;
    idle_all();
  endtask

  task automatic expect_rd(input string req, input bit side, input int idx, input logic exp);
    logic v;
    rd1(side, idx, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset();
    #1; chk("R9 idle left", l_rdata, 1'b1);
    chk("R9 idle right", r_rdata, 1'b1);
    for (int i = 0; i < NT; i++) begin
      expect_rd("R9 left free", 0, i, 1'b1);
      expect_rd("R9 right free", 1, i, 1'b1);
    end
  endtask

  task automatic t_claim();
    wr1(0, 2, 1'b0);
    expect_rd("R3 left owns 2", 0, 2, 1'b0);
    expect_rd("R4 right sees not-own 2", 1, 2, 1'b1);
    wr1(0, 2, 1'b1);
    expect_rd("R4 left freed 2", 0, 2, 1'b1);
    wr1(1, 2, 1'b0);
    expect_rd("R3 right owns 2", 1, 2, 1'b0);
    wr1(1, 2, 1'b1);
  endtask

  task automatic t_indep();
    wr1(0, 5, 1'b0);
    wr1(1, 6, 1'b0);
    expect_rd("R1 left owns 5", 0, 5, 1'b0);
    expect_rd("R1 right owns 6", 1, 6, 1'b0);
    expect_rd("R1 left not 6", 0, 6, 1'b1);
    expect_rd("R1 right not 5", 1, 5, 1'b1);
    wr1(1, 4, 1'b0);
    expect_rd("R1 right gets 4", 1, 4, 1'b0);
    expect_rd("R1 left still 5", 0, 5, 1'b0);
    wr1(0, 5, 1'b1); wr1(1, 6, 1'b1); wr1(1, 4, 1'b1);
    expect_rd("R1 5 free", 1, 5, 1'b1);
  endtask

  task automatic t_pending();
    wr1(0, 3, 1'b0);
    wr1(1, 3, 1'b0);
    expect_rd("R5 right waits", 1, 3, 1'b1);
    expect_rd("R5 left keeps", 0, 3, 1'b0);
    wr1(0, 3, 1'b1);
    expect_rd("R6 right granted", 1, 3, 1'b0);
    expect_rd("R6 left released", 0, 3, 1'b1);
    wr1(1, 3, 1'b1);
    expect_rd("R6 freed", 1, 3, 1'b1);
  endtask

  task automatic t_tie();
    wr_both(1, 1'b0, 1'b0);
    expect_rd("R7 left wins", 0, 1, 1'b0);
    expect_rd("R7 right loses", 1, 1, 1'b1);
    wr1(0, 1, 1'b1);
    expect_rd("R7 right pending granted", 1, 1, 1'b0);
    wr1(1, 1, 1'b1);
  endtask

  task automatic t_release_rules();
    wr1(0, 0, 1'b0);
    wr1(1, 0, 1'b1);
    expect_rd("R8 stray release no effect", 0, 0, 1'b0);
    expect_rd("R8 right still not owner", 1, 0, 1'b1);
    wr1(1, 0, 1'b0);
    wr1(1, 0, 1'b1);
    wr1(0, 0, 1'b1);
    expect_rd("R8 cancelled not granted", 1, 0, 1'b1);
    expect_rd("R8 left released", 0, 0, 1'b1);
    wr1(0, 0, 1'b0);
    expect_rd("R8 token 0 still usable", 0, 0, 1'b0);
    wr1(0, 0, 1'b1);
  endtask

  task automatic t_gate();
    logic v;
    wr1(0, 7, 1'b0, 1'b1, 1'b0);
    expect_rd("R2 enable low write ignored", 0, 7, 1'b1);
    wr1(0, 7, 1'b0, 1'b0, 1'b1);
    expect_rd("R2 select low write ignored", 0, 7, 1'b1);
    wr1(0, 7, 1'b0);
    rd1(0, 7, v, 1'b1, 1'b0);
    chk("R2 enable low read is 1", v, 1'b1);
    wr1(0, 7, 1'b1, 1'b0, 1'b1);
    expect_rd("R2 masked release ignored", 0, 7, 1'b0);
    wr1(0, 7, 1'b1);
  endtask

  task automatic t_rereq();
    wr1(0, 4, 1'b0);
    wr1(0, 4, 1'b0);
    expect_rd("R10 still owner", 0, 4, 1'b0);
    wr1(0, 4, 1'b1);
    expect_rd("R10 one release frees", 0, 4, 1'b1);
    wr1(1, 4, 1'b0);
    expect_rd("R10 right claims freed", 1, 4, 1'b0);
    wr1(1, 4, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_claim();
    t_indep();
    t_pending();
    t_tie();
    t_release_rules();
    t_gate();
    t_rereq();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule